// File: doc/BRIEF.md
# Serial Audio-Link Input Frame Receiver

This block sits on the controller side of a time-slotted serial audio link and turns the incoming serial stream into parallel words. The codec launches each bit on a rising edge of the bit clock. The receiver captures it on the following falling edge. The frame sync is produced elsewhere by the controller and is only observed here. A rising sync marks the start of a frame.

Each frame has two parts. The first is a 16-bit tag slot holding a codec-ready flag and one valid flag for each of the twelve data slots. The second is twelve 20-bit data slots, sent most significant bit first.

The receiver works in a fast system clock domain. It brings the bit clock, sync and data in through a synchronizer and acts on each detected falling edge of the bit clock.

- **Per-slot output:** every valid slot produces a one-cycle strobe with the slot number and its word.
- **Per-frame output:** after slot 12, a frame strobe presents the tag, the returned status index and data, and the ten PCM words. Each of these is forced to zero when its valid flag is clear.
- **Early sync:** a sync that rises before a frame is complete makes the receiver realign to the new frame and pulse a framing-error flag.

Top module: `alink_rx`

## Requirements
- R1: After reset all strobes (`slot_stb`, `frame_stb`, `frame_err`) are low and `frame_tag`, `stat_idx`, `stat_data` and `pcm_words` are zero.
- R2: A frame starts when the sync level, sampled at a falling bit-clock edge, is 1 and the previous sample was 0. The next falling-edge sample is frame bit 0. Samples taken while no frame is open produce no output.
- R3: Frame bits 0 to 15 form the tag word, first bit in tag bit 15. Tag bit 15 is codec ready, and tag bit 15-k is the valid flag of slot k for k = 1..12. `frame_tag` reports tag bits 2..0 as zero whatever was received.
- R4: Frame bits 16 to 255 form twelve 20-bit slots in order 1..12, each received most significant bit first.
- R5: When slot k completes and its valid flag is 1, `slot_stb` pulses for one clock with `slot_id` = k and `slot_word` = the received word. An invalid slot gives no pulse.
- R6: When slot 12 completes, `frame_stb` pulses for one clock. `pcm_words[(k-3)*20 +: 20]` then holds slot k for k = 3..12, or zero when that slot's flag is clear.
- R7: With the frame strobe, `stat_idx` is bits 18..12 of slot 1 if slot 1 is valid, else 0. `stat_data` is slot 2 if slot 2 is valid, else 0.
- R8: A sync rise seen while a frame is open and before its bit 255 pulses `frame_err` for one clock. The partial frame gives no `frame_stb`, and the new frame is decoded normally.
- R9: A sync rise sampled together with bit 255 of the open frame completes that frame with no error and starts the next one.
- R10: After bit 255, if sync stays low, the receiver waits for the next sync rise without output or error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Serial bit clock from the codec |
| sync_in | input | 1 | Frame sync as driven by the controller |
| sdata_in | input | 1 | Serial data from the codec |
| slot_stb | output | 1 | One-cycle strobe for a completed valid slot |
| slot_id | output | 4 | Number (1..12) of the slot in `slot_word` |
| slot_word | output | 20 | Received slot word |
| frame_stb | output | 1 | One-cycle strobe after slot 12 |
| frame_tag | output | 16 | Tag word of the frame, bits 2..0 zero |
| stat_idx | output | 7 | Returned status register index, gated by slot 1 flag |
| stat_data | output | 20 | Returned status data, gated by slot 2 flag |
| pcm_words | output | 200 | Slots 3..12, each gated by its flag |
| frame_err | output | 1 | One-cycle pulse on an early sync rise |

## Verification
The bench builds the block with its default parameters: a 16-bit tag, twelve 20-bit slots, a two-stage synchronizer and a 7-bit index at bit 12. A full 256-bit frame with a bit period of eight system clocks is then about 2,000 cycles, so six frames fit easily. This reaches several cases in one run:
- back-to-back frames whose sync rise shares a sample with the final bit;
- a frame cut short after 100 bits, followed at once by a complete frame;
- noise on the data line while no frame is open;
- frames where invalid slots carry nonzero data, which must be gated to zero.

// File: rtl/alink_pkg.sv
package alink_pkg;

  // Position of the valid flag of data slot k inside the tag word.
  function automatic int flag_bit(input int tag_w, input int k);
    return tag_w - 1 - k;
  endfunction

  // Number of low tag bits that carry no meaning.
  function automatic int ign_bits(input int tag_w, input int num_slots);
    return tag_w - 1 - num_slots;
  endfunction

  // Width wide enough for a bit position inside the longest slot.
  function automatic int pos_width(input int tag_w, input int slot_w);
    return (tag_w > slot_w) ? $clog2(tag_w) : $clog2(slot_w);
  endfunction

endpackage

// File: rtl/alink_edge_sync.sv
module alink_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_clk,
  input  logic sync_in,
  input  logic sdata_in,
  output logic smp_stb,
  output logic smp_bit,
  output logic smp_sync
);

  // All three lines share one chain so they stay aligned to each other.
  logic [STAGES-1:0][2:0] chain_q;
  logic                   bclk_prev_q;
  logic [2:0]             cur;
  logic                   fall;

  assign cur  = chain_q[STAGES-1];
  assign fall = bclk_prev_q & ~cur[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q     <= '0;
      bclk_prev_q <= 1'b0;
      smp_stb     <= 1'b0;
      smp_bit     <= 1'b0;
      smp_sync    <= 1'b0;
    end else begin
      chain_q     <= {chain_q[STAGES-2:0], {bit_clk, sync_in, sdata_in}};
      bclk_prev_q <= cur[2];
      smp_stb     <= fall;
      if (fall) begin
        smp_bit  <= cur[0];
        smp_sync <= cur[1];
      end
    end
  end

  // One sample per bit period: a falling edge cannot repeat on the next clock.
  assert_single_sample_R2: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> !smp_stb);

endmodule

// File: rtl/alink_frame_ctr.sv
module alink_frame_ctr #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int SID_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_stb,
  input  logic             smp_bit,
  input  logic             smp_sync,
  output logic             bit_stb,
  output logic             bit_val,
  output logic [SID_W-1:0] bit_slot,
  output logic             bit_eos,
  output logic             bit_eof,
  output logic             frame_err
);

  localparam int PW = alink_pkg::pos_width(TAG_W, SLOT_W);

  logic             sync_prev_q;
  logic             open_q;
  logic [SID_W-1:0] slot_q;
  logic [PW-1:0]    pos_q;
  logic             rise;
  logic             at_slot_end;
  logic             at_frame_end;

  assign rise         = smp_sync & ~sync_prev_q;
  assign at_slot_end  = (slot_q == '0) ? (pos_q == PW'(TAG_W - 1))
                                       : (pos_q == PW'(SLOT_W - 1));
  assign at_frame_end = (slot_q == SID_W'(NUM_SLOTS)) && (pos_q == PW'(SLOT_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_prev_q <= 1'b0;
      open_q      <= 1'b0;
      slot_q      <= '0;
      pos_q       <= '0;
      bit_stb     <= 1'b0;
      bit_val     <= 1'b0;
      bit_slot    <= '0;
      bit_eos     <= 1'b0;
      bit_eof     <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      bit_stb   <= 1'b0;
      bit_eos   <= 1'b0;
      bit_eof   <= 1'b0;
      frame_err <= 1'b0;
      if (smp_stb) begin
        sync_prev_q <= smp_sync;
        bit_stb     <= open_q;
        bit_val     <= smp_bit;
        bit_slot    <= slot_q;
        bit_eos     <= open_q & at_slot_end;
        bit_eof     <= open_q & at_frame_end;
        if (rise) begin
          frame_err <= open_q & ~at_frame_end;
          open_q    <= 1'b1;
          slot_q    <= '0;
          pos_q     <= '0;
        end else if (open_q) begin
          if (at_frame_end) begin
            open_q <= 1'b0;
            slot_q <= '0;
            pos_q  <= '0;
          end else if (at_slot_end) begin
            slot_q <= slot_q + 1'b1;
            pos_q  <= '0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
      end
    end
  end

  assert_slot_range_R4: assert property (@(posedge clk) disable iff (rst)
    (slot_q <= SID_W'(NUM_SLOTS)) && ((slot_q == '0) ? (pos_q < PW'(TAG_W)) : (pos_q < PW'(SLOT_W))));

  // After an early sync the counters stand at the start of a fresh frame.
  assert_err_realign_R8: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> (open_q && slot_q == '0 && pos_q == '0));

  assert_eof_last_slot_R6: assert property (@(posedge clk) disable iff (rst)
    bit_eof |-> (bit_eos && bit_stb && bit_slot == SID_W'(NUM_SLOTS)));

endmodule

// File: rtl/alink_slot_deser.sv
module alink_slot_deser #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int SID_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bit_stb,
  input  logic                        bit_val,
  input  logic [SID_W-1:0]            bit_slot,
  input  logic                        bit_eos,
  input  logic                        bit_eof,
  output logic                        word_stb,
  output logic [SID_W-1:0]            word_id,
  output logic [SLOT_W-1:0]           word_data,
  output logic [TAG_W-1:0]            tag_q,
  output logic [NUM_SLOTS*SLOT_W-1:0] words_q,
  output logic                        frame_done
);

  logic [SLOT_W-1:0] sh_q;
  logic [SLOT_W-1:0] sh_nx;
  logic              slot_end;
  logic              flag_cur;

  assign sh_nx    = {sh_q[SLOT_W-2:0], bit_val};
  assign slot_end = bit_stb & bit_eos;

  function automatic logic flag_of(input logic [TAG_W-1:0] t, input logic [SID_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int k = 1; k <= NUM_SLOTS; k++) begin
      if (s == SID_W'(k)) r = t[alink_pkg::flag_bit(TAG_W, k)];
    end
    return r;
  endfunction

  assign flag_cur = flag_of(tag_q, bit_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      tag_q      <= '0;
      word_stb   <= 1'b0;
      word_id    <= '0;
      word_data  <= '0;
      frame_done <= 1'b0;
    end else begin
      word_stb   <= 1'b0;
      frame_done <= bit_stb & bit_eof;
      if (bit_stb) sh_q <= sh_nx;
      if (slot_end && bit_slot == '0) tag_q <= sh_nx[TAG_W-1:0];
      if (slot_end && bit_slot != '0 && flag_cur) begin
        word_stb  <= 1'b1;
        word_id   <= bit_slot;
        word_data <= sh_nx;
      end
    end
  end

  // One register per slot holds the gated word until the frame is reported.
  for (genvar k = 1; k <= NUM_SLOTS; k++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst) begin
        words_q[(k-1)*SLOT_W +: SLOT_W] <= '0;
      end else if (slot_end && bit_slot == SID_W'(k)) begin
        words_q[(k-1)*SLOT_W +: SLOT_W] <= flag_cur ? sh_nx : '0;
      end
    end
  end

  assert_word_flag_R5: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> (word_id != '0 && word_id <= SID_W'(NUM_SLOTS) && flag_of(tag_q, word_id)));

  assert_word_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> !word_stb);

endmodule

// File: rtl/alink_frame_out.sv
module alink_frame_out #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int IDX_W     = 7,
  parameter int IDX_LSB   = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            frame_done,
  input  logic [TAG_W-1:0]                tag_in,
  input  logic [NUM_SLOTS*SLOT_W-1:0]     words_in,
  output logic                            frame_stb,
  output logic [TAG_W-1:0]                frame_tag,
  output logic [IDX_W-1:0]                stat_idx,
  output logic [SLOT_W-1:0]               stat_data,
  output logic [(NUM_SLOTS-2)*SLOT_W-1:0] pcm_words
);

  localparam int IGN_W = alink_pkg::ign_bits(TAG_W, NUM_SLOTS);

  logic unused_bits;
  assign unused_bits = ^{tag_in[IGN_W-1:0], words_in[SLOT_W-1:IDX_LSB+IDX_W],
                         words_in[IDX_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_stb <= 1'b0;
      frame_tag <= '0;
      stat_idx  <= '0;
      stat_data <= '0;
      pcm_words <= '0;
    end else begin
      frame_stb <= frame_done;
      if (frame_done) begin
        frame_tag <= {tag_in[TAG_W-1:IGN_W], {IGN_W{1'b0}}};
        stat_idx  <= words_in[IDX_LSB +: IDX_W];
        stat_data <= words_in[SLOT_W +: SLOT_W];
        pcm_words <= words_in[NUM_SLOTS*SLOT_W-1 : 2*SLOT_W];
      end
    end
  end

  assert_frame_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> !frame_stb);

  assert_frame_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(pcm_words) && $stable(frame_tag));

endmodule

// File: rtl/alink_rx.sv
module alink_rx #(
  parameter int TAG_W       = 16,
  parameter int SLOT_W      = 20,
  parameter int NUM_SLOTS   = 12,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 7,
  parameter int IDX_LSB     = 12,
  parameter int SID_W       = $clog2(NUM_SLOTS + 1)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bit_clk,
  input  logic                            sync_in,
  input  logic                            sdata_in,
  output logic                            slot_stb,
  output logic [SID_W-1:0]                slot_id,
  output logic [SLOT_W-1:0]               slot_word,
  output logic                            frame_stb,
  output logic [TAG_W-1:0]                frame_tag,
  output logic [IDX_W-1:0]                stat_idx,
  output logic [SLOT_W-1:0]               stat_data,
  output logic [(NUM_SLOTS-2)*SLOT_W-1:0] pcm_words,
  output logic                            frame_err
);

  logic                        smp_stb, smp_bit, smp_sync;
  logic                        bit_stb, bit_val, bit_eos, bit_eof;
  logic [SID_W-1:0]            bit_slot;
  logic [TAG_W-1:0]            tag_q;
  logic [NUM_SLOTS*SLOT_W-1:0] words_q;
  logic                        frame_done;

  alink_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bit_clk(bit_clk), .sync_in(sync_in), .sdata_in(sdata_in),
    .smp_stb(smp_stb), .smp_bit(smp_bit), .smp_sync(smp_sync)
  );

  alink_frame_ctr #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .SID_W(SID_W)) u_ctr (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_bit(smp_bit), .smp_sync(smp_sync),
    .bit_stb(bit_stb), .bit_val(bit_val), .bit_slot(bit_slot), .bit_eos(bit_eos),
    .bit_eof(bit_eof), .frame_err(frame_err)
  );

  alink_slot_deser #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .SID_W(SID_W)) u_deser (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val), .bit_slot(bit_slot),
    .bit_eos(bit_eos), .bit_eof(bit_eof), .word_stb(slot_stb), .word_id(slot_id),
    .word_data(slot_word), .tag_q(tag_q), .words_q(words_q), .frame_done(frame_done)
  );

  alink_frame_out #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
                    .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_out (
    .clk(clk), .rst(rst), .frame_done(frame_done), .tag_in(tag_q), .words_in(words_q),
    .frame_stb(frame_stb), .frame_tag(frame_tag), .stat_idx(stat_idx),
    .stat_data(stat_data), .pcm_words(pcm_words)
  );

  assert_err_not_frame_R8: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> !frame_stb);

endmodule

// File: tb/tb_alink_rx.sv
module tb_alink_rx;

  logic         clk = 1'b0;
  logic         rst;
  logic         bit_clk, sync_in, sdata_in;
  logic         slot_stb, frame_stb, frame_err;
  logic [3:0]   slot_id;
  logic [19:0]  slot_word, stat_data;
  logic [15:0]  frame_tag;
  logic [6:0]   stat_idx;
  logic [199:0] pcm_words;

  always #4 clk = ~clk;

  alink_rx dut (
    .clk(clk), .rst(rst), .bit_clk(bit_clk), .sync_in(sync_in), .sdata_in(sdata_in),
    .slot_stb(slot_stb), .slot_id(slot_id), .slot_word(slot_word),
    .frame_stb(frame_stb), .frame_tag(frame_tag), .stat_idx(stat_idx),
    .stat_data(stat_data), .pcm_words(pcm_words), .frame_err(frame_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int slot_seen = 0, frame_seen = 0, err_seen = 0;
  bit done = 1'b0;
  logic carry = 1'b0;
  logic [19:0] w [1:12];

  logic [23:0]  q_slot [$];
  logic [15:0]  q_tag  [$];
  logic [6:0]   q_idx  [$];
  logic [19:0]  q_dat  [$];
  logic [199:0] q_pcm  [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One bit period: eight system clocks, lines change with the rising bit clock.
  task automatic period(input logic s, input logic d);
    @(negedge clk);
    bit_clk = 1'b1; sync_in = s; sdata_in = d;
    repeat (4) @(negedge clk);
    bit_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    period(1'b0, carry);
    carry = 1'b0;
    for (int i = 1; i < n; i++) period(1'b0, logic'((i % 3) == 1));
  endtask

  // Driver: pushes expectations, then sends nbits of a frame; the last bit rides with the next sync or idle.
  task automatic send_frame(input logic [15:0] tag, input int nbits);
    logic [255:0] fb;
    logic [199:0] pcm;
    fb = '0;
    fb[255:240] = tag;
    pcm = '0;
    for (int k = 1; k <= 12; k++) begin
      fb[239-(k-1)*20 -: 20] = w[k];
      if (15 + 20*k <= nbits - 1 && tag[15-k]) q_slot.push_back({4'(k), w[k]});
      if (k >= 3 && tag[15-k]) pcm[(k-3)*20 +: 20] = w[k];
    end
    if (nbits == 256) begin
      q_tag.push_back(tag & 16'hFFF8);
      q_idx.push_back(tag[14] ? w[1][18:12] : 7'd0);
      q_dat.push_back(tag[13] ? w[2] : 20'd0);
      q_pcm.push_back(pcm);
    end
    period(1'b1, carry);
    for (int i = 0; i < nbits - 1; i++) period(logic'(i < 15), fb[255-i]);
    carry = fb[256-nbits];
  endtask

  task automatic fill_words(input int seed);
    for (int k = 1; k <= 12; k++) w[k] = 20'((k * 32'h1D3B7 + seed * 32'h5A5A1) ^ 32'h8_0000);
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (frame_err) err_seen++;
      if (slot_stb) begin
        slot_seen++;
        if (q_slot.size() == 0) chk(1'b0, "R5", "unexpected slot strobe", 256'({slot_id, slot_word}), 0);
        else begin
          logic [23:0] e;
          e = q_slot.pop_front();
          chk(slot_id == e[23:20], "R5", "slot id", 256'(slot_id), 256'(e[23:20]));
          chk(slot_word == e[19:0], "R4", "slot word msb-first", 256'(slot_word), 256'(e[19:0]));
        end
      end
      if (frame_stb) begin
        frame_seen++;
        if (q_tag.size() == 0) chk(1'b0, "R8", "unexpected frame strobe", 256'(frame_tag), 0);
        else begin
          logic [15:0] et; logic [6:0] ei; logic [19:0] ed; logic [199:0] ep;
          et = q_tag.pop_front(); ei = q_idx.pop_front();
          ed = q_dat.pop_front(); ep = q_pcm.pop_front();
          chk(frame_tag == et, "R3", "frame tag", 256'(frame_tag), 256'(et));
          chk(stat_idx == ei, "R7", "status index", 256'(stat_idx), 256'(ei));
          chk(stat_data == ed, "R7", "status data", 256'(stat_data), 256'(ed));
          chk(pcm_words == ep, "R6", "pcm words", 256'(pcm_words), 256'(ep));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bit_clk = 1'b0; sync_in = 1'b0; sdata_in = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!slot_stb && !frame_stb && !frame_err, "R1", "strobes after reset",
        256'({slot_stb, frame_stb, frame_err}), 0);
    chk(frame_tag == 0 && stat_idx == 0 && stat_data == 0 && pcm_words == 0, "R1",
        "frame outputs after reset", 256'(pcm_words), 0);

    // R2: noise with no sync opens no frame
    idle(40);
    chk(slot_seen == 0 && frame_seen == 0, "R2", "strobes before first sync",
        256'(slot_seen + frame_seen), 0);

    fill_words(1);  send_frame(16'hFFFF, 256);   // all valid, ignored bits set
    fill_words(2);  send_frame(16'h5408, 256);   // slots 1,3,5,12 valid (R9 back-to-back)
    fill_words(3);  send_frame(16'h8000, 256);   // nothing valid
    // R9: two back-to-back frames finished, no error
    chk(err_seen == 0, "R9", "error count on back-to-back frames", 256'(err_seen), 0);
    chk(frame_seen == 2, "R9", "frames finished", 256'(frame_seen), 2);

    fill_words(4);  send_frame(16'hFFFF, 100);   // cut short (R8)
    fill_words(5);  send_frame(16'h7FF5, 256);
    idle(30);
    chk(err_seen == 1, "R8", "framing error pulses", 256'(err_seen), 1);
    chk(frame_seen == 4, "R8", "partial frame not reported", 256'(frame_seen), 4);

    // R10: after idle gap, resync without error
    fill_words(6);  send_frame(16'hE249, 256);
    idle(10);
    chk(err_seen == 1, "R10", "no error after idle gap", 256'(err_seen), 1);
    chk(frame_seen == 5, "R10", "frame after idle gap", 256'(frame_seen), 5);
    chk(q_slot.size() == 0, "R5", "slot events outstanding", 256'(q_slot.size()), 0);
    chk(q_tag.size() == 0, "R6", "frame events outstanding", 256'(q_tag.size()), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule